// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over many clock cycles and returns the 64-bit product as an upper word and a lower word. It holds the multiplicand in a register of its own and keeps one 64-bit working register. At the start of a run the multiplier operand sits in the lower half of that register and the upper half is cleared. Each iteration looks at bit 0 of the working register. When that bit is set, one 32-bit adder adds the multiplicand into the upper half. The whole register, with the adder's carry on top, then shifts right by one place. The multiplicand itself never moves.

A caller drives both operands and a mode select and pulses `start` while the block is idle. In signed mode each negative operand is replaced by its magnitude before the iterations. When exactly one operand was negative, the 64-bit result is negated in a final correction cycle. In unsigned mode the operands are used as given. `busy` stays high for the whole run and `done` pulses once when `hi`/`lo` take the new product.

The control is a three-state machine. `ST_IDLE` waits for a start request; the transition idle-to-run loads the operands. `ST_RUN` performs one shift-add iteration per cycle; the transition run-to-fix is taken on the last iteration. `ST_FIX` applies the sign correction and writes the outputs; the transition fix-to-idle raises `done`.

Top module: `shift_add_mul`

## Requirements
- R1: After reset `busy` is 0, `done` is 0 and `hi` and `lo` are both 0.
- R2: With `signed_mode` = 0, `{hi,lo}` equals the unsigned 64-bit product of `op_a` and `op_b`.
- R3: With `signed_mode` = 1, `{hi,lo}` equals the two's-complement 64-bit product of `op_a` and `op_b`, including operands of -2^31.
- R4: With `signed_mode` = 0, an operand whose bit 31 is set is treated as a large positive value and no sign correction is applied.
- R5: A start sampled while idle makes `busy` high for exactly 33 cycles (32 iterations and one correction cycle). `done` is high in the first cycle after that, and `busy` is low in the same cycle.
- R6: `done` is high for exactly one cycle per run. `hi` and `lo` change only in a cycle where `done` is high and hold in every other cycle.
- R7: A `start` pulse while `busy` is high is ignored: the running product and its timing are unaffected and no extra result is produced.
- R8: A `start` pulse in the cycle where `done` is high is accepted as a new run.
- R9: The carry of each 32-bit add is kept, so 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE_00000001 in unsigned mode. A zero operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply; taken only while idle |
| op_a | input | 32 | Multiplicand operand |
| op_b | input | 32 | Multiplier operand |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when `hi`/`lo` are updated |
| hi | output | 32 | Upper 32 bits of the product |
| lo | output | 32 | Lower 32 bits of the product |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. The block leaves `ST_FIX` and is idle in the same cycle that `done` is high, so a start arriving then is taken at once. The bench provokes this by raising `start` at the very sample point where it first sees `done`. The overlap is judged correct when both queued products come out in order and the second run again shows exactly 33 busy cycles. A second test puts a start pulse in the middle of a run, and the bench confirms that only the first operand pair produces a result.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mul_state_t;

endpackage

// File: rtl/mul_operand_mag.sv
module mul_operand_mag #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic             sign_en,
    output logic [WIDTH-1:0] magnitude,
    output logic             was_neg
);

    always_comb begin
        was_neg   = sign_en & value[WIDTH-1];
        magnitude = was_neg ? (~value + 1'b1) : value;
    end

endmodule

// File: rtl/mul_step_dp.sv
module mul_step_dp #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    work_q;
    logic [WIDTH:0]   add_res;
    logic [WIDTH-1:0] addend;

    always_comb begin
        addend  = work_q[0] ? mcand_q : '0;
        add_res = {1'b0, work_q[PW-1:WIDTH]} + {1'b0, addend};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            work_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            work_q  <= {{WIDTH{1'b0}}, mplier_in};
        end else if (step) begin
            work_q  <= {add_res, work_q[WIDTH-1:1]};
        end
    end

    assign product = work_q;

endmodule

// File: rtl/mul_result_fix.sv
module mul_result_fix #(
    parameter int PW = 64
) (
    input  logic [PW-1:0] raw,
    input  logic          negate,
    output logic [PW-1:0] fixed
);

    always_comb begin
        fixed = negate ? (~raw + 1'b1) : raw;
    end

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             signed_mode,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);

    import mulseq_pkg::*;

    localparam int PW = 2 * WIDTH;
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

    mul_state_t state_q, state_d;
    logic [CW-1:0] iter_q;
    logic          neg_q;
    logic          load_en, step_en;

    logic [WIDTH-1:0] mag_a, mag_b;
    logic             neg_a, neg_b;
    logic [PW-1:0]    raw_prod, fixed_prod;

    mul_operand_mag #(.WIDTH(WIDTH)) u_mag_a (
        .value(op_a), .sign_en(signed_mode), .magnitude(mag_a), .was_neg(neg_a)
    );

    mul_operand_mag #(.WIDTH(WIDTH)) u_mag_b (
        .value(op_b), .sign_en(signed_mode), .magnitude(mag_b), .was_neg(neg_b)
    );

    mul_step_dp #(.WIDTH(WIDTH)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load_en), .step(step_en),
        .mcand_in(mag_a), .mplier_in(mag_b), .product(raw_prod)
    );

    mul_result_fix #(.PW(PW)) u_fix (
        .raw(raw_prod), .negate(neg_q), .fixed(fixed_prod)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (iter_q == LAST_ITER) state_d = ST_FIX;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign load_en = (state_q == ST_IDLE) && start;
    assign step_en = (state_q == ST_RUN);

    // state register and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            neg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_en) begin
                iter_q <= '0;
                neg_q  <= neg_a ^ neg_b;
            end else if (step_en) begin
                iter_q <= iter_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            hi   <= '0;
            lo   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_FIX: begin
                    done <= 1'b1;
                    hi   <= fixed_prod[PW-1:WIDTH];
                    lo   <= fixed_prod[WIDTH-1:0];
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo
);

    localparam int LW = $clog2(WIDTH + 2) + 1;

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < LW'(WIDTH + 1)));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo)));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .hi(hi), .lo(lo)
);

// File: tb/shift_add_mul_test.sv
`timescale 1ns/1ps
module shift_add_mul_test;

    typedef struct {
        logic [63:0] exp;
        string       req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        signed_mode = 1'b0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int errors = 0;
    int checks = 0;
    int done_seen = 0;
    int busy_cnt = 0;
    logic [63:0] last_out = '0;
    exp_item_t sb[$];

    always #2 clk = ~clk;

    shift_add_mul uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .signed_mode(signed_mode), .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input logic s);
        longint sa, sb2;
        logic [63:0] ua, ub;
        if (s) begin
            sa = longint'($signed(a));
            sb2 = longint'($signed(b));
            return 64'(sa * sb2);
        end
        ua = {32'b0, a};
        ub = {32'b0, b};
        return ua * ub;
    endfunction

    // monitor: pops expected items on done, checks latency and hold
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (done) begin
                exp_item_t it;
                if (sb.size() == 0) begin
                    check("R7 unexpected result", {hi, lo}, 64'hx);
                end else begin
                    it = sb.pop_front();
                    check(it.req, {hi, lo}, it.exp);
                    check({it.req, " R5 latency"}, 64'(busy_cnt), 64'd33);
                end
                busy_cnt = 0;
                last_out = {hi, lo};
                done_seen++;
            end else begin
                if ({hi, lo} !== last_out) check("R6 hold", {hi, lo}, last_out);
            end
        end
    end

    // assumes the caller is at a falling edge
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s, input string req);
        exp_item_t it;
        op_a = a; op_b = b; signed_mode = s; start = 1'b1;
        it.exp = model(a, b, s);
        it.req = req;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s, input string req);
        int target;
        target = done_seen + 1;
        issue(a, b, s, req);
        wait (done_seen == target);
        @(negedge clk);
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 hi/lo", {hi, lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(32'd8, 32'd9, 1'b0, "R2 small unsigned");
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R2 mixed unsigned");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 max carry");
        run_op(32'h0, 32'hDEAD_BEEF, 1'b0, "R9 zero multiplicand");
        run_op(32'hCAFE_F00D, 32'h0, 1'b1, "R9 zero multiplier");
        run_op(32'h8000_0000, 32'd2, 1'b0, "R4 top bit unsigned");
        run_op(32'hFFFF_FFF9, 32'd2, 1'b0, "R4 no correction");
        run_op(32'hFFFF_FFF9, 32'd2, 1'b1, "R3 neg*pos");
        run_op(32'd7, 32'hFFFF_FFFE, 1'b1, "R3 pos*neg");
        run_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, "R3 neg*neg");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R3 min*min");
        run_op(32'h8000_0000, 32'd1, 1'b1, "R3 min*one");

        // R7: start while busy is ignored
        begin
            int target;
            target = done_seen + 1;
            issue(32'd1000, 32'd1001, 1'b0, "R7 first operands kept");
            repeat (5) @(negedge clk);
            op_a = 32'd5; op_b = 32'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (done_seen == target);
            repeat (40) @(negedge clk);
            check("R7 no extra result", 64'(done_seen), 64'(target));
        end

        // R8: start in the done cycle
        begin
            int target;
            target = done_seen + 1;
            issue(32'h0001_0001, 32'h0001_0001, 1'b0, "R8 first of pair");
            wait (done_seen == target);
            issue(32'hFFFF_FFFF, 32'd3, 1'b1, "R8 started on done");
            wait (done_seen == target + 1);
            @(negedge clk);
        end

        check("R8 queue drained", 64'(sb.size()), 64'd0);
        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule